// File: doc/BRIEF.md
# Multicycle 8-bit Register-File Processor Core

This block is a small multicycle processor with an 8-bit datapath. It keeps a loadable program counter, an instruction register, a program store, a register file with eight 8-bit registers, an eight-function ALU, a 256-byte data RAM and an outbound byte stream. Every instruction passes through a fetch state, a decode state and one execute state chosen by its opcode. A Moore controller sequences these states, and its fetch state has the code 0.

A host fills the program store through a plain write port while it holds the core in reset. It then releases reset and collects the bytes that the core emits on its output stream. Instructions are 16 bits wide. The opcode sits in bits [15:11]. The destination and first source register, Rx, sits in bits [10:8]. Bits [7:0] hold an immediate, a two's-complement branch offset or a data address. The second source register, Ry, sits in bits [7:5].

The output stream uses a valid/ready handshake. `out_valid` is high only while an output instruction executes. While `out_ready` is low, the core stalls in that state and holds `out_data` steady. A byte counts as delivered on a rising edge where `out_valid` and `out_ready` are both high. The core takes no further instruction until that happens.

Top module: `cpu8_core`

## Requirements
- R1: A synchronous reset returns the controller to fetch and the program counter to 0. `out_valid` is low during reset, and after release execution restarts from program address 0.
- R2: A defined instruction other than output takes exactly three clock cycles: fetch, decode and execute. Fetch loads the instruction at the current PC into the instruction register and increments the PC.
- R3: Opcode 00001 writes the 8-bit field [7:0] into register Rx.
- R4: Opcode 00011 sets Rx to Rx + Ry and opcode 00101 sets Rx to Rx - Ry, both modulo 256, with Ry taken from bits [7:5].
- R5: Opcode 00100 replaces Rx with its bitwise complement.
- R6: Opcode 00110 adds the sign-extended field [7:0] to the already-incremented PC when Rx is zero. When Rx is not zero it leaves the PC unchanged. Negative offsets branch backwards.
- R7: Opcode 00111 loads Rx from data RAM address [7:0], and opcode 01000 stores Rx to data RAM address [7:0]. Addresses 0 and 255 are both usable.
- R8: Opcode 00010 raises `out_valid` with `out_data` equal to Rx during its execute state. While `out_ready` is low, the core stays in that state with `out_valid` high and `out_data` unchanged. It moves on to fetch after the handshake edge.
- R9: Any other opcode, including 00000 and 11111, changes no register, RAM location or output. Such an instruction returns to fetch right after decode, so it takes two cycles.
- R10: A rising edge with `prog_we` high writes `prog_data` into program address `prog_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | PC_W (8) | Program store write address |
| prog_data | input | 16 | Instruction word to store |
| out_data | output | DW (8) | Output stream byte, zero while not valid |
| out_valid | output | 1 | Output stream byte valid |
| out_ready | input | 1 | Output stream consumer ready |

## Verification
The bench builds the core with its default values: 8-bit data, eight registers and an 8-bit program counter. With these values the 8-bit wrap on add and subtract is reachable, and so are the data RAM's address extremes, 0 and 255. A negative branch offset closes a twenty-pass countdown loop, and a branch offset of -1 makes an idle self-loop. A per-cycle behavioural model checks the fetch, decode and execute timing. It also checks output stalls under a periodic `out_ready` pattern and restarts after a reset asserted mid-program.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam int OPW = 5;

  localparam logic [OPW-1:0] OP_MOVI  = 5'b00001;
  localparam logic [OPW-1:0] OP_OUT   = 5'b00010;
  localparam logic [OPW-1:0] OP_ADD   = 5'b00011;
  localparam logic [OPW-1:0] OP_INV   = 5'b00100;
  localparam logic [OPW-1:0] OP_SUB   = 5'b00101;
  localparam logic [OPW-1:0] OP_JZ    = 5'b00110;
  localparam logic [OPW-1:0] OP_LOAD  = 5'b00111;
  localparam logic [OPW-1:0] OP_STORE = 5'b01000;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MOVI   = 4'd2,
    S_OUT    = 4'd3,
    S_ADD    = 4'd4,
    S_INV    = 4'd5,
    S_SUB    = 4'd6,
    S_JZ     = 4'd7,
    S_LOAD   = 4'd8,
    S_STORE  = 4'd9
  } state_e;

  typedef enum logic [2:0] {
    ALU_PASS = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_AND  = 3'd3,
    ALU_OR   = 3'd4,
    ALU_NOT  = 3'd5,
    ALU_INC  = 3'd6,
    ALU_SHL  = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    WSRC_ALU = 2'd0,
    WSRC_IMM = 2'd1,
    WSRC_MEM = 2'd2
  } wsrc_e;

  typedef struct packed {
    logic    ir_ld;
    logic    pc_inc;
    logic    pc_br;
    logic    rf_we;
    wsrc_e   wsrc;
    logic    rd_a;
    logic    rd_b;
    alu_op_e alu_op;
    logic    dm_we;
    logic    out_vld;
  } ctrl_t;

  function automatic logic op_known(input logic [OPW-1:0] op);
    return (op >= OP_MOVI) && (op <= OP_STORE);
  endfunction

endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y,
  output logic          zero
);

  always_comb begin
    unique case (op)
      ALU_PASS: y = a;
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_NOT:  y = ~a;
      ALU_INC:  y = a + DW'(1);
      ALU_SHL:  y = {a[DW-2:0], 1'b0};
      default:  y = a;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          rea,
  input  logic [AW-1:0] raa,
  input  logic          reb,
  input  logic [AW-1:0] rab,
  output logic [DW-1:0] rda,
  output logic [DW-1:0] rdb
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[wa] <= wd;
  end

  assign rda = rea ? regs[raa] : '0;
  assign rdb = reb ? regs[rab] : '0;

endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           out_ready,
  output state_e         state,
  output ctrl_t          ctrl
);

  state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    nxt = S_FETCH;
    unique case (state)
      S_FETCH: nxt = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OP_MOVI:  nxt = S_MOVI;
          OP_OUT:   nxt = S_OUT;
          OP_ADD:   nxt = S_ADD;
          OP_INV:   nxt = S_INV;
          OP_SUB:   nxt = S_SUB;
          OP_JZ:    nxt = S_JZ;
          OP_LOAD:  nxt = S_LOAD;
          OP_STORE: nxt = S_STORE;
          default:  nxt = S_FETCH;
        endcase
      end
      S_OUT:   nxt = out_ready ? S_FETCH : S_OUT;
      default: nxt = S_FETCH;
    endcase
  end

  // Moore outputs: a function of the state alone
  always_comb begin
    ctrl = '0;
    unique case (state)
      S_FETCH: begin
        ctrl.ir_ld  = 1'b1;
        ctrl.pc_inc = 1'b1;
      end
      S_MOVI: begin
        ctrl.rf_we = 1'b1;
        ctrl.wsrc  = WSRC_IMM;
      end
      S_OUT: begin
        ctrl.rd_a    = 1'b1;
        ctrl.alu_op  = ALU_PASS;
        ctrl.out_vld = 1'b1;
      end
      S_ADD, S_SUB: begin
        ctrl.rd_a   = 1'b1;
        ctrl.rd_b   = 1'b1;
        ctrl.alu_op = (state == S_ADD) ? ALU_ADD : ALU_SUB;
        ctrl.rf_we  = 1'b1;
        ctrl.wsrc   = WSRC_ALU;
      end
      S_INV: begin
        ctrl.rd_a   = 1'b1;
        ctrl.alu_op = ALU_NOT;
        ctrl.rf_we  = 1'b1;
        ctrl.wsrc   = WSRC_ALU;
      end
      S_JZ: begin
        ctrl.rd_a   = 1'b1;
        ctrl.alu_op = ALU_PASS;
        ctrl.pc_br  = 1'b1;
      end
      S_LOAD: begin
        ctrl.rf_we = 1'b1;
        ctrl.wsrc  = WSRC_MEM;
      end
      S_STORE: begin
        ctrl.rd_a  = 1'b1;
        ctrl.dm_we = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  assert_reset_to_fetch_R1: assert property (@(posedge clk)
    rst |=> state == S_FETCH);

  assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> state == S_DECODE);

  assert_exec_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (state != S_FETCH && state != S_DECODE && state != S_OUT) |=> state == S_FETCH);

  assert_unknown_op_skips_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && !op_known(opcode)) |=> state == S_FETCH);

  assert_out_waits_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_OUT && !out_ready) |=> state == S_OUT);

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 8,
  parameter int PC_W = 8,
  localparam int RAW   = $clog2(NREG),
  localparam int IW    = OPW + RAW + DW,
  localparam int PDEP  = 2 ** PC_W,
  localparam int DDEP  = 2 ** DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_we,
  input  logic [PC_W-1:0] prog_addr,
  input  logic [IW-1:0]   prog_data,
  output logic [DW-1:0]   out_data,
  output logic            out_valid,
  input  logic            out_ready
);

  logic [IW-1:0]   prog_mem [PDEP];
  logic [DW-1:0]   dmem     [DDEP];
  logic [PC_W-1:0] pc;
  logic [IW-1:0]   ir;

  state_e state;
  ctrl_t  ctrl;

  logic [OPW-1:0] op;
  logic [RAW-1:0] rx, ry;
  logic [DW-1:0]  imm;
  logic [DW-1:0]  rda, rdb, alu_y, wdata, dm_rd;
  logic           alu_zero;

  assign op  = ir[IW-1 -: OPW];
  assign rx  = ir[DW+RAW-1 : DW];
  assign ry  = ir[DW-1 -: RAW];
  assign imm = ir[DW-1:0];

  // program store, filled through the load port
  always_ff @(posedge clk) begin
    if (prog_we) prog_mem[prog_addr] <= prog_data;
  end

  // instruction register and program counter
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else if (ctrl.ir_ld) begin
      ir <= prog_mem[pc];
      pc <= pc + PC_W'(1);
    end else if (ctrl.pc_br && alu_zero) begin
      pc <= pc + PC_W'($signed(imm));
    end
  end

  cpu8_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opcode    (op),
    .out_ready (out_ready),
    .state     (state),
    .ctrl      (ctrl)
  );

  cpu8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk (clk),
    .we  (ctrl.rf_we),
    .wa  (rx),
    .wd  (wdata),
    .rea (ctrl.rd_a),
    .raa (rx),
    .reb (ctrl.rd_b),
    .rab (ry),
    .rda (rda),
    .rdb (rdb)
  );

  cpu8_alu #(.DW(DW)) u_alu (
    .a    (rda),
    .b    (rdb),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data RAM, direct addressing from the instruction's low field
  always_ff @(posedge clk) begin
    if (ctrl.dm_we) dmem[imm] <= rda;
  end
  assign dm_rd = dmem[imm];

  always_comb begin
    unique case (ctrl.wsrc)
      WSRC_IMM: wdata = imm;
      WSRC_MEM: wdata = dm_rd;
      default:  wdata = alu_y;
    endcase
  end

  assign out_valid = ctrl.out_vld;
  assign out_data  = ctrl.out_vld ? alu_y : '0;

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_fetch_steps_pc_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> pc == $past(pc) + PC_W'(1));

  assert_branch_untaken_R6: assert property (@(posedge clk) disable iff (rst)
    (state == S_JZ && rda != '0) |=> $stable(pc));

  assert_no_write_outside_exec_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH || state == S_DECODE) |-> !(ctrl.rf_we || ctrl.dm_we));

endmodule

// File: tb/sim_cpu8_core.sv
module sim_cpu8_core;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, NREG = 8, PC_W = 8, IW = 16;

  logic clk = 1'b0, rst = 1'b1, prog_we = 1'b0, out_ready = 1'b1;
  logic [PC_W-1:0] prog_addr = '0;
  logic [IW-1:0]   prog_data = '0;
  logic [DW-1:0]   out_data;
  logic            out_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu8_core #(.DW(DW), .NREG(NREG), .PC_W(PC_W)) u0 (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit bp_en = 1'b0, started = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int rx, input int imm);
    return {op[4:0], rx[2:0], imm[7:0]};
  endfunction

  // behavioural reference model
  logic [15:0] mprog [256];
  logic [7:0]  mreg  [8];
  logic [7:0]  mmem  [256];
  logic [15:0] mir = '0;
  logic [7:0]  mpc = '0;
  int          mph = 0;
  int          q[$];
  bit          pv = 0, pr = 0;
  logic [7:0]  pd = '0;

  always @(posedge clk) begin
    pv = out_valid && !rst; pr = out_ready; pd = out_data;
    if (!rst && out_valid && out_ready) q.push_back(int'(out_data));
    if (rst) begin
      mph = 0; mpc = '0;
    end else begin
      case (mph)
        0: begin mir = mprog[mpc]; mpc = mpc + 8'd1; mph = 1; end
        1: mph = (mir[15:11] >= 5'd1 && mir[15:11] <= 5'd8) ? 2 : 0;
        default: begin
          mph = 0;
          case (mir[15:11])
            5'd1: mreg[mir[10:8]] = mir[7:0];
            5'd2: if (!out_ready) mph = 2;
            5'd3: mreg[mir[10:8]] = mreg[mir[10:8]] + mreg[mir[7:5]];
            5'd4: mreg[mir[10:8]] = ~mreg[mir[10:8]];
            5'd5: mreg[mir[10:8]] = mreg[mir[10:8]] - mreg[mir[7:5]];
            5'd6: if (mreg[mir[10:8]] == 8'd0) mpc = mpc + mir[7:0];
            5'd7: mreg[mir[10:8]] = mmem[mir[7:0]];
            5'd8: mmem[mir[7:0]] = mreg[mir[10:8]];
            default: ;
          endcase
        end
      endcase
    end
    started = 1'b1;
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      automatic bit mv = (mph == 2) && (mir[15:11] == 5'd2);
      check(out_valid == mv, "R2 R8 R9 per-cycle valid", int'(out_valid), int'(mv));
      if (mv) check(out_data == mreg[mir[10:8]], "R3 R4 R5 R6 R7 per-cycle data",
                    int'(out_data), int'(mreg[mir[10:8]]));
      if (pv && !pr && !rst)
        check(out_valid && out_data == pd, "R8 stall hold", int'(out_data), int'(pd));
    end
  end

  always @(negedge clk) out_ready <= bp_en ? ((cyc % 3) != 0) : 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic load(input int addr, input logic [15:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = addr[7:0]; prog_data = w;
    mprog[addr] = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic wait_outs(input int n);
    for (int i = 0; i < 3000 && q.size() < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic time_first_out(output int cnt);
    cnt = 0;
    do begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end while (!out_valid && cnt < 50);
  endtask

  initial begin
    int cnt;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid low in reset", int'(out_valid), 0);

    // program 1: countdown loop, RAM round trip, complement, unknown opcodes (R10 load port)
    load(0,  enc(1, 0, 0));
    load(1,  enc(1, 1, 20));
    load(2,  enc(1, 2, 2));
    load(3,  enc(1, 3, 1));
    load(4,  enc(1, 7, 0));
    load(5,  enc(3, 0, 2 << 5));
    load(6,  enc(5, 1, 3 << 5));
    load(7,  enc(6, 1, 1));
    load(8,  enc(6, 7, -4));
    load(9,  enc(2, 0, 0));
    load(10, enc(8, 0, 32));
    load(11, enc(7, 4, 32));
    load(12, enc(2, 4, 0));
    load(13, enc(4, 4, 0));
    load(14, enc(2, 4, 0));
    load(15, enc(31, 0, 255));
    load(16, enc(0, 0, 7));
    load(17, enc(2, 0, 0));
    load(18, enc(2, 1, 0));
    load(19, enc(6, 7, -1));
    bp_en = 1'b1;
    rst = 1'b0;
    wait_outs(5);
    check(q.size() == 5, "R10 program 1 output count", q.size(), 5);
    if (q.size() == 5) begin
      check(q[0] == 40, "R4 R6 countdown sum", q[0], 40);
      check(q[1] == 40, "R7 RAM round trip", q[1], 40);
      check(q[2] == 215, "R5 complement", q[2], 215);
      check(q[3] == 40, "R9 unknown opcodes inert", q[3], 40);
      check(q[4] == 0, "R4 counter reached zero", q[4], 0);
    end

    // program 2: wraparound, untaken and forward branch, RAM extremes
    rst = 1'b1;
    bp_en = 1'b0;
    q.delete();
    load(0,  enc(1, 5, 200));
    load(1,  enc(1, 6, 100));
    load(2,  enc(3, 5, 6 << 5));
    load(3,  enc(2, 5, 0));
    load(4,  enc(1, 2, 0));
    load(5,  enc(1, 3, 1));
    load(6,  enc(5, 2, 3 << 5));
    load(7,  enc(2, 2, 0));
    load(8,  enc(6, 2, 2));
    load(9,  enc(2, 3, 0));
    load(10, enc(8, 2, 255));
    load(11, enc(8, 6, 0));
    load(12, enc(7, 1, 255));
    load(13, enc(7, 4, 0));
    load(14, enc(2, 1, 0));
    load(15, enc(2, 4, 0));
    load(16, enc(1, 0, 0));
    load(17, enc(6, 0, 2));
    load(18, enc(2, 5, 0));
    load(19, enc(2, 5, 0));
    load(20, enc(2, 6, 0));
    load(21, enc(6, 0, -1));
    rst = 1'b0;
    wait_outs(6);
    repeat (30) @(negedge clk);
    check(q.size() == 6, "R6 forward branch skips outputs", q.size(), 6);
    if (q.size() >= 6) begin
      check(q[0] == 44, "R4 add wraps", q[0], 44);
      check(q[1] == 255, "R4 sub wraps", q[1], 255);
      check(q[2] == 1, "R6 untaken branch falls through", q[2], 1);
      check(q[3] == 255, "R7 address 255", q[3], 255);
      check(q[4] == 100, "R7 address 0", q[4], 100);
      check(q[5] == 100, "R6 branch target", q[5], 100);
    end

    // program 3: cycle timing and mid-run reset
    rst = 1'b1;
    q.delete();
    load(0, enc(1, 0, 5));
    load(1, enc(0, 0, 0));
    load(2, enc(2, 0, 0));
    load(3, enc(1, 7, 0));
    load(4, enc(6, 7, -1));
    rst = 1'b0;
    time_first_out(cnt);
    check(cnt == 7, "R2 R9 cycles to first output", cnt, 7);
    check(out_data == 8'd5, "R3 immediate value", int'(out_data), 5);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid low in mid-run reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    time_first_out(cnt);
    check(cnt == 7, "R1 restart from address 0", cnt, 7);
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule